// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns a fast system clock into two clock phases that never overlap. An internal oscillator built from a cycle counter produces a slow square wave: it stays high for a programmed number of system clocks, then low for another programmed number. A second pair of counts gives a slower standby rate, and an idle input picks which pair applies. A toggle flip-flop flips on each falling edge of the oscillator, which halves its rate. The true and complement outputs of the toggle are each gated with the oscillator to form phase 1 and phase 2.

Each phase therefore lasts one oscillator high interval, and the phases alternate between oscillator periods. The oscillator low interval is a gap in which neither phase is active. The phase outputs are registered in the system clock domain, so they follow the oscillator one system clock late and carry no combinational glitches. The oscillator waveform is also brought out.

Top module: `twophase_clkgen`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it, `osc` is 1 and both `ph1` and `ph2` are 0. Reset clears the toggle, so the first phase pulse after reset is on `ph2`.
- R2: `osc` stays high for exactly the active high count (`hi_idle` when idle is in force, otherwise `hi_run`), in system clock cycles.
- R3: `osc` stays low for exactly the active low count (`lo_idle` when idle is in force, otherwise `lo_run`), in system clock cycles.
- R4: `idle` is sampled only at reset and at the start of each high interval (the low-to-high change of `osc`). A change of `idle` at any other time has no effect until the next period boundary.
- R5: The toggle flips on every falling edge of `osc`, so the phases alternate, `ph2` then `ph1` then `ph2`, with exactly one phase pulse in each oscillator period.
- R6: `ph1` in cycle n+1 equals toggle AND `osc` in cycle n (the toggle is 1 after an odd number of `osc` falls since reset).
- R7: `ph2` in cycle n+1 equals NOT toggle AND `osc` in cycle n.
- R8: `ph1` and `ph2` are never high together. Both are low in every cycle whose preceding cycle had `osc` low.
- R9: A count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| idle | input | 1 | 1 selects the standby count pair |
| hi_run | input | CW | High interval in cycles, normal rate |
| lo_run | input | CW | Low interval in cycles, normal rate |
| hi_idle | input | CW | High interval in cycles, standby rate |
| lo_idle | input | CW | Low interval in cycles, standby rate |
| osc | output | 1 | Oscillator waveform |
| ph1 | output | 1 | Phase 1, registered |
| ph2 | output | 1 | Phase 2, registered |

## Verification
The hardest case to reach is an `idle` change that falls inside an oscillator period. The count pair must then stay fixed until the next low-to-high change of `osc`. A directed segment flips `idle` every few cycles between two count pairs that differ greatly. Random stretches then change `idle`, the counts and the reset at random cycles. This covers changes that land in a high interval, in a low interval, and in the boundary cycle itself. Further corner cases are counts of one and zero, where a whole interval lasts a single system clock.

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic [CW-1:0] hi_run,
  input  logic [CW-1:0] lo_run,
  input  logic [CW-1:0] hi_idle,
  input  logic [CW-1:0] lo_idle,
  output logic          osc,
  output logic          ph1,
  output logic          ph2
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt, cur_hi, cur_lo;
  logic          tgl;

  wire [CW-1:0] sel_hi  = idle ? hi_idle : hi_run;
  wire [CW-1:0] sel_lo  = idle ? lo_idle : lo_run;
  wire [CW-1:0] nz_hi   = (sel_hi == '0) ? ONE : sel_hi;
  wire [CW-1:0] nz_lo   = (sel_lo == '0) ? ONE : sel_lo;
  wire          hi_done = osc && (cnt == cur_hi - ONE);
  wire          lo_done = !osc && (cnt == cur_lo - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      osc    <= 1'b1;
      cnt    <= '0;
      tgl    <= 1'b0;
      ph1    <= 1'b0;
      ph2    <= 1'b0;
      cur_hi <= nz_hi;
      cur_lo <= nz_lo;
    end else begin
      ph1 <= tgl & osc;
      ph2 <= ~tgl & osc;
      if (hi_done) begin
        osc <= 1'b0;
        cnt <= '0;
        tgl <= ~tgl;
      end else if (lo_done) begin
        osc    <= 1'b1;
        cnt    <= '0;
        cur_hi <= nz_hi;
        cur_lo <= nz_lo;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (osc && !ph1 && !ph2));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !(ph1 && ph2));

  p_low_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(osc) |-> (!ph1 && !ph2));

  p_phase_needs_osc_r6: assert property (@(posedge clk) disable iff (rst)
    (ph1 || ph2) |-> $past(osc));

  p_toggle_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(osc) |-> (tgl != $past(tgl)));

  p_pair_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(osc && !$past(osc)) |-> ($stable(cur_hi) && $stable(cur_lo)));

  p_count_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    (cur_hi != '0) && (cur_lo != '0));
endmodule

// File: tb/twophase_clkgen_tb_top.sv
module twophase_clkgen_tb_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle = 1'b0;
  logic [CW-1:0] hi_run = 8'd3, lo_run = 8'd2, hi_idle = 8'd5, lo_idle = 8'd4;
  logic osc, ph1, ph2;

  int checks = 0;
  int fails  = 0;
  string seg_tag = "";
  bit done = 1'b0;

  always #10 clk = ~clk;

  twophase_clkgen #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .idle(idle),
    .hi_run(hi_run), .lo_run(lo_run), .hi_idle(hi_idle), .lo_idle(lo_idle),
    .osc(osc), .ph1(ph1), .ph2(ph2)
  );

  function automatic int clamp1(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, stepped once per rising edge
  bit m_osc, m_tgl, m_ph1, m_ph2, m_rst_d;
  int m_cnt, m_hi, m_lo;
  always @(posedge clk) begin
    bit o, t;
    o = m_osc; t = m_tgl;
    m_rst_d = rst;
    if (rst) begin
      m_osc = 1; m_cnt = 0; m_tgl = 0; m_ph1 = 0; m_ph2 = 0;
      m_hi = clamp1(idle ? hi_idle : hi_run);
      m_lo = clamp1(idle ? lo_idle : lo_run);
    end else begin
      m_ph1 = t & o;
      m_ph2 = ~t & o;
      if (o) begin
        if (m_cnt >= m_hi - 1) begin m_osc = 0; m_cnt = 0; m_tgl = ~t; end
        else m_cnt++;
      end else begin
        if (m_cnt >= m_lo - 1) begin
          m_osc = 1; m_cnt = 0;
          m_hi = clamp1(idle ? hi_idle : hi_run);
          m_lo = clamp1(idle ? lo_idle : lo_run);
        end else m_cnt++;
      end
    end
  end

  // port monitor, away from the active edge
  bit p1_d, p2_d, last_is_ph1, seen_any;
  always @(negedge clk) begin
    if (!done) begin
      string otag;
      otag = (seg_tag != "") ? seg_tag : (m_osc ? "R2" : "R3");
      if (m_rst_d) begin
        check(osc === 1'b1 && ph1 === 1'b0 && ph2 === 1'b0, "R1 reset state",
              {29'd0, osc, ph1, ph2}, 4);
        seen_any = 0;
      end else begin
        check(osc === m_osc, otag, osc, m_osc);
        check(ph1 === m_ph1, "R6", ph1, m_ph1);
        check(ph2 === m_ph2, "R7", ph2, m_ph2);
        check(!(ph1 && ph2), "R8 overlap", {30'd0, ph1, ph2}, 0);
        if (ph1 && !p1_d) begin
          check(seen_any && !last_is_ph1, "R5 ph1 order", seen_any, 1);
          last_is_ph1 = 1; seen_any = 1;
        end
        if (ph2 && !p2_d) begin
          check(!seen_any || last_is_ph1, "R5 ph2 order", last_is_ph1, 1);
          last_is_ph1 = 0; seen_any = 1;
        end
      end
      p1_d = ph1; p2_d = ph2;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cycles(3);
    rst = 1'b0;
    cycles(60);
    // minimal counts
    hi_run = 1; lo_run = 1;
    cycles(30);
    // zero counts treated as one
    seg_tag = "R9";
    hi_run = 0; lo_run = 0; hi_idle = 0; lo_idle = 7;
    cycles(20);
    idle = 1; cycles(40);
    seg_tag = "";
    // idle flips mid-period, far-apart pairs
    seg_tag = "R4";
    hi_run = 2; lo_run = 1; hi_idle = 23; lo_idle = 17;
    for (int i = 0; i < 60; i++) begin
      idle = ~idle;
      cycles(3);
    end
    seg_tag = "";
    // constrained random
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) hi_run = 8'($urandom_range(0, 12));
      if ($urandom_range(0, 7) == 0) lo_run = 8'($urandom_range(0, 12));
      if ($urandom_range(0, 7) == 0) hi_idle = 8'($urandom_range(0, 20));
      if ($urandom_range(0, 7) == 0) lo_idle = 8'($urandom_range(0, 20));
      if ($urandom_range(0, 5) == 0) idle = ~idle;
      rst = ($urandom_range(0, 60) == 0);
      cycles($urandom_range(1, 25));
    end
    rst = 1'b0;
    cycles(100);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule